// File: doc/BRIEF.md
# Instruction-Class Power-Gating Sequencer

This controller sits beside a small non-pipelined 32-bit RISC core with the embedded register set and the multiply/divide extension, clocked very slowly so that leakage dominates. The core finishes each instruction before it fetches the next. For every instruction the controller accepts the fetched word, works out which execute sub-unit it needs, and powers the stage domains one at a time: decode, then the single matching execute sub-unit, then writeback when the instruction writes a register. Each domain comes up in a fixed order: power enable, settle, isolation release, stage strobe. When the instruction retires, every domain except fetch is isolated, the register-file domain is put into retention, and power is removed.

Two schedules are offered. The early-shutdown schedule gives each stage only as many cycles as its power-up needs. The fixed schedule gives every stage an equal slot of `SLOT_CYC` cycles. The power switches and the datapath sit outside the block. Switch readiness comes back on a per-domain wake-acknowledge input, and a settle counter of `SETTLE_CYC` cycles stands in when no acknowledge arrives.

Domain indices used on every vector port: 0 fetch, 1 decode, 2 ALU, 3 shifter, 4 multiply/divide, 5 load/store, 6 branch/jump, 7 writeback (register file).

Top module: `pgate_seq`

## Requirements
- R1: While reset is high and after it is released, `pwr_en` is 8'h01, `iso` is 8'hFE, `ret` is 0, `stage_act` is 0, `illegal_err` is 0 and `idle` is 1.
- R2: The execute domain is chosen from opcode instr[6:0], funct3 instr[14:12] and funct7 instr[31:25]. Opcode 0110011 with funct7 0000001 selects domain 4. Opcodes 0110011 and 0010011 with funct3 001 or 101 select domain 3. Other 0110011/0010011 cases and opcodes 0110111/0010111 select domain 2. Opcodes 0000011/0100011 select domain 5. Opcodes 1100011/1101111/1100111 select domain 6.
- R3: An instruction is accepted on a clock edge where `idle` and `fetch_valid` are both high. That edge raises `stage_act[0]` for one cycle. The domains then power up one after another, decode, execute, then writeback, and each raises its own `stage_act` bit exactly once, in that order.
- R4: Stores (0100011), conditional branches (1100011) and illegal opcodes skip the writeback stage; every other instruction uses it.
- R5: Each stage asserts its power enable, then releases isolation (and clears retention) on the first edge where its `wake_ack` bit is high or the settle count of `SETTLE_CYC` cycles has expired, then pulses `stage_act` on the next edge. In early mode a stage lasts 3 cycles with an immediate acknowledge and `SETTLE_CYC`+2 cycles without one.
- R6: With `fixed_mode` high, every stage lasts max(`SLOT_CYC`, its early-mode length) cycles.
- R7: After the last stage, all non-fetch domains are isolated. One cycle later, retention is asserted on the writeback domain if it is powered. One cycle after that, power is dropped and `idle` returns. From the accept edge, `idle` stays low for (stages × stage length) + 2 cycles.
- R8: Any opcode not listed in R2 powers decode and the ALU domain only, and raises `illegal_err` for exactly one cycle.
- R9: The fetch domain is never powered down. A `fetch_valid` that arrives while `idle` is low has no effect.
- R10: At most one execute sub-unit domain (2 to 6) is powered at any time, and a `stage_act` bit rises only on a powered, de-isolated, non-retained domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fixed_mode | input | 1 | 1 selects equal stage slots, 0 selects early shutdown |
| fetch_valid | input | 1 | Fetched instruction word is valid |
| instr | input | 32 | Fetched instruction word |
| wake_ack | input | 8 | Per-domain power switch ready |
| pwr_en | output | 8 | Per-domain power enable |
| iso | output | 8 | Per-domain output isolation |
| ret | output | 8 | Per-domain state retention |
| stage_act | output | 8 | Per-domain one-cycle stage strobe to the datapath |
| illegal_err | output | 1 | One-cycle unrecognised-opcode flag |
| idle | output | 1 | Ready to accept the next instruction |

## Verification
Every output is a register, so each result becomes visible one cycle after the edge that decides it. The fetch strobe and error flag appear in the first sample after the accept edge, and a stage strobe follows its isolation release by one cycle. The bench drives inputs on falling edges and samples once per cycle, also on the falling edge. It counts low-`idle` samples after the accept edge and compares that count with a length computed from R5 to R7. It also compares the order of the stage strobes and the union of all powered domains with the values R2 to R4 predict. The wake acknowledge is either tied low or tied to `pwr_en`, so both settle paths are timed.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int NDOM = 8;
  localparam int DW   = $clog2(NDOM);

  localparam int D_FETCH  = 0;
  localparam int D_DEC    = 1;
  localparam int D_ALU    = 2;
  localparam int D_SHIFT  = 3;
  localparam int D_MULDIV = 4;
  localparam int D_LSU    = 5;
  localparam int D_BRANCH = 6;
  localparam int D_WB     = 7;

  localparam logic [NDOM-1:0] FETCH_MASK = NDOM'(1) << D_FETCH;
  localparam logic [NDOM-1:0] RET_MASK   = NDOM'(1) << D_WB;
  localparam logic [NDOM-1:0] EXEC_MASK  = NDOM'(8'b0111_1100);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUP, ST_ACT, ST_WAIT, ST_DNRET, ST_DNOFF
  } seq_st_t;
endpackage

// File: rtl/pgs_decode.sv
module pgs_decode
  import pgs_pkg::*;
(
  input  logic [31:0]   instr,
  output logic [DW-1:0] exec_dom,
  output logic          need_wb,
  output logic          illegal
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       is_shift_f3;
  logic       unused_fields;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign is_shift_f3   = (f3 == 3'b001) || (f3 == 3'b101);
  assign unused_fields = ^{instr[24:15], instr[11:7]};

  always_comb begin
    exec_dom = DW'(D_ALU);
    need_wb  = 1'b1;
    illegal  = 1'b0;
    case (opc)
      7'b0110011: begin
        if (f7 == 7'b0000001)  exec_dom = DW'(D_MULDIV);
        else if (is_shift_f3)  exec_dom = DW'(D_SHIFT);
      end
      7'b0010011: if (is_shift_f3) exec_dom = DW'(D_SHIFT);
      7'b0110111, 7'b0010111: exec_dom = DW'(D_ALU);
      7'b0000011: exec_dom = DW'(D_LSU);
      7'b0100011: begin
        exec_dom = DW'(D_LSU);
        need_wb  = 1'b0;
      end
      7'b1100011: begin
        exec_dom = DW'(D_BRANCH);
        need_wb  = 1'b0;
      end
      7'b1101111, 7'b1100111: exec_dom = DW'(D_BRANCH);
      default: begin
        illegal = 1'b1;
        need_wb = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
  import pgs_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SLOT_CYC   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fixed_mode,
  input  logic            fetch_valid,
  input  logic [DW-1:0]   dec_dom,
  input  logic            dec_wb,
  input  logic            dec_illegal,
  input  logic [NDOM-1:0] wake_ack,
  output logic [NDOM-1:0] pwr_en,
  output logic [NDOM-1:0] iso,
  output logic [NDOM-1:0] ret,
  output logic [NDOM-1:0] stage_act,
  output logic            illegal_err,
  output logic            idle
);
  localparam int MAXC = ((SLOT_CYC > SETTLE_CYC + 2) ? SLOT_CYC : SETTLE_CYC + 2) + 1;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_t       state;
  logic [1:0]    stg;
  logic [DW-1:0] exec_q;
  logic          wb_q;
  logic [CW-1:0] settle_cnt;
  logic [CW-1:0] slot_cnt;
  logic [DW-1:0] cur_dom;
  logic [DW-1:0] nxt_dom;
  logic          last_stg;
  logic          settled;
  logic          slot_done;

  always_comb begin
    case (stg)
      2'd0:    cur_dom = DW'(D_DEC);
      2'd1:    cur_dom = exec_q;
      default: cur_dom = DW'(D_WB);
    endcase
    nxt_dom  = (stg == 2'd0) ? exec_q : DW'(D_WB);
    last_stg = (stg == 2'd2) || ((stg == 2'd1) && !wb_q);
  end

  assign settled   = wake_ack[cur_dom] || (settle_cnt == CW'(SETTLE_CYC - 1));
  assign slot_done = !fixed_mode || (slot_cnt >= CW'(SLOT_CYC - 1));
  assign idle      = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      stg         <= '0;
      exec_q      <= DW'(D_ALU);
      wb_q        <= 1'b0;
      settle_cnt  <= '0;
      slot_cnt    <= '0;
      pwr_en      <= FETCH_MASK;
      iso         <= ~FETCH_MASK;
      ret         <= '0;
      stage_act   <= '0;
      illegal_err <= 1'b0;
    end else begin
      stage_act   <= '0;
      illegal_err <= 1'b0;
      if (slot_cnt != '1) slot_cnt <= slot_cnt + 1'b1;
      case (state)
        ST_IDLE: if (fetch_valid) begin
          exec_q             <= dec_dom;
          wb_q               <= dec_wb;
          illegal_err        <= dec_illegal;
          stage_act[D_FETCH] <= 1'b1;
          stg                <= '0;
          pwr_en[D_DEC]      <= 1'b1;
          settle_cnt         <= '0;
          slot_cnt           <= '0;
          state              <= ST_PUP;
        end
        ST_PUP: if (settled) begin
          iso[cur_dom] <= 1'b0;
          ret[cur_dom] <= 1'b0;
          state        <= ST_ACT;
        end else begin
          settle_cnt <= settle_cnt + 1'b1;
        end
        ST_ACT: begin
          stage_act[cur_dom] <= 1'b1;
          state              <= ST_WAIT;
        end
        ST_WAIT: if (slot_done) begin
          if (last_stg) begin
            iso   <= ~FETCH_MASK;
            state <= ST_DNRET;
          end else begin
            stg             <= stg + 2'd1;
            pwr_en[nxt_dom] <= 1'b1;
            settle_cnt      <= '0;
            slot_cnt        <= '0;
            state           <= ST_PUP;
          end
        end
        ST_DNRET: begin
          ret   <= ret | (RET_MASK & pwr_en);
          state <= ST_DNOFF;
        end
        ST_DNOFF: begin
          pwr_en <= FETCH_MASK;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
  import pgs_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SLOT_CYC   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fixed_mode,
  input  logic        fetch_valid,
  input  logic [31:0] instr,
  input  logic [7:0]  wake_ack,
  output logic [7:0]  pwr_en,
  output logic [7:0]  iso,
  output logic [7:0]  ret,
  output logic [7:0]  stage_act,
  output logic        illegal_err,
  output logic        idle
);
  logic [DW-1:0] dec_dom;
  logic          dec_wb;
  logic          dec_illegal;

  pgs_decode u_dec (
    .instr    (instr),
    .exec_dom (dec_dom),
    .need_wb  (dec_wb),
    .illegal  (dec_illegal)
  );

  pgs_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .SLOT_CYC   (SLOT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .fixed_mode  (fixed_mode),
    .fetch_valid (fetch_valid),
    .dec_dom     (dec_dom),
    .dec_wb      (dec_wb),
    .dec_illegal (dec_illegal),
    .wake_ack    (wake_ack),
    .pwr_en      (pwr_en),
    .iso         (iso),
    .ret         (ret),
    .stage_act   (stage_act),
    .illegal_err (illegal_err),
    .idle        (idle)
  );
endmodule

// File: rtl/pgate_seq_chk.sv
module pgate_seq_chk
  import pgs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NDOM-1:0] pwr_en,
  input logic [NDOM-1:0] iso,
  input logic [NDOM-1:0] ret,
  input logic [NDOM-1:0] stage_act,
  input logic            illegal_err,
  input logic            idle
);
  AST_FETCH_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst) pwr_en[D_FETCH]); // R9
  AST_BUSY_NO_FETCH_STROBE: assert property (@(posedge clk) disable iff (rst) !idle |=> !stage_act[D_FETCH]); // R9
  AST_ONE_EXEC_UNIT: assert property (@(posedge clk) disable iff (rst) $countones(pwr_en & EXEC_MASK) <= 1); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0(stage_act)); // R3
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst) illegal_err |=> !illegal_err); // R8
  AST_WB_RET_AT_OFF: assert property (@(posedge clk) disable iff (rst) (!pwr_en[D_WB] && $past(pwr_en[D_WB])) |-> ret[D_WB]); // R7

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    AST_OFF_MEANS_ISO: assert property (@(posedge clk) disable iff (rst) !pwr_en[d] |-> iso[d]); // R7
    AST_ISO_BEFORE_OFF: assert property (@(posedge clk) disable iff (rst) (!pwr_en[d] && $past(pwr_en[d])) |-> ($past(iso[d]) && iso[d])); // R7
    AST_STROBE_LIVE: assert property (@(posedge clk) disable iff (rst) stage_act[d] |-> (pwr_en[d] && !iso[d] && !ret[d])); // R10
    AST_RELEASE_AFTER_EN: assert property (@(posedge clk) disable iff (rst) $fell(iso[d]) |-> $past(pwr_en[d])); // R5
  end
endmodule

bind pgate_seq pgate_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_en      (pwr_en),
  .iso         (iso),
  .ret         (ret),
  .stage_act   (stage_act),
  .illegal_err (illegal_err),
  .idle        (idle)
);

// File: tb/pgate_seq_test.sv
`timescale 1ns/1ps
module pgate_seq_test;
  localparam int SETTLE = 4;
  localparam int SLOT   = 8;

  typedef struct packed {
    logic [31:0] ins;
    logic        fx;
    logic        fa;
    logic [2:0]  dom;
    logic        wb;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h003100B3, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
    '{32'h003110B3, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0},
    '{32'h403150B3, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0},
    '{32'h023100B3, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0},
    '{32'h023140B3, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0},
    '{32'h00510093, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0},
    '{32'h00511093, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0},
    '{32'h00012083, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0},
    '{32'h00112023, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0},
    '{32'h00208063, 1'b0, 1'b0, 3'd6, 1'b0, 1'b0},
    '{32'h008000EF, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0},
    '{32'h000080E7, 1'b0, 1'b1, 3'd6, 1'b1, 1'b0},
    '{32'h000010B7, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1},
    '{32'h00000000, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fixed_mode = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        fast = 1'b0;
  logic [7:0]  wake_ack;
  logic [7:0]  pwr_en, iso, ret, stage_act;
  logic        illegal_err, idle;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int         busy, nerr, nact;
  logic [7:0] seen;
  int         act_log [8];

  always #2.5 clk = ~clk;
  assign wake_ack = fast ? pwr_en : 8'h00;

  pgate_seq #(.SETTLE_CYC(SETTLE), .SLOT_CYC(SLOT)) uut (
    .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .fetch_valid(fetch_valid),
    .instr(instr), .wake_ack(wake_ack), .pwr_en(pwr_en), .iso(iso), .ret(ret),
    .stage_act(stage_act), .illegal_err(illegal_err), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic fx, input logic fa, input logic wb);
    int l = fa ? 3 : SETTLE + 2;
    if (fx && SLOT > l) l = SLOT;
    return (wb ? 3 : 2) * l + 2;
  endfunction

  task automatic run_one(input logic [31:0] ins, input logic fx, input logic fa,
                         input bit spur_en, input logic [31:0] spur);
    @(negedge clk);
    instr = ins; fixed_mode = fx; fast = fa; fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    busy = 0; nerr = 0; nact = 0; seen = '0;
    while (!idle && busy < 400) begin
      seen |= pwr_en;
      if (illegal_err) nerr++;
      for (int b = 0; b < 8; b++)
        if (stage_act[b] && nact < 8) begin act_log[nact] = b; nact++; end
      busy++;
      if (spur_en && busy == 2) begin instr = spur; fetch_valid = 1'b1; end
      else fetch_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pwr_en == 8'h01, "R1 pwr_en in reset", pwr_en, 8'h01);
    chk(iso == 8'hFE, "R1 iso in reset", iso, 8'hFE);
    rst = 1'b0;
    @(negedge clk);
    chk(pwr_en == 8'h01 && iso == 8'hFE, "R1 pwr/iso after reset", {pwr_en, iso}, 16'h01FE);
    chk(ret == 8'h00 && stage_act == 8'h00, "R1 ret/act after reset", {ret, stage_act}, 0);
    chk(idle && !illegal_err, "R1 idle/err after reset", {idle, illegal_err}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      logic [7:0] exp_seen = 8'h03 | (8'h01 << t.dom) | (t.wb ? 8'h80 : 8'h00);
      int exp_nact = t.wb ? 4 : 3;
      run_one(t.ins, t.fx, t.fa, 1'b0, 32'h0);
      chk(seen == exp_seen, "R2 R4 R10 powered domains", seen, exp_seen);
      chk(busy == exp_len(t.fx, t.fa, t.wb), "R5 R6 R7 busy cycles", busy, exp_len(t.fx, t.fa, t.wb));
      chk(nact == exp_nact, "R3 R4 strobe count", nact, exp_nact);
      chk(act_log[0] == 0 && act_log[1] == 1 && act_log[2] == int'(t.dom),
          "R3 strobe order", act_log[2], t.dom);
      if (t.wb) chk(act_log[3] == 7, "R3 writeback strobe last", act_log[3], 7);
      chk(nerr == int'(t.err), "R8 error pulse count", nerr, t.err);
      chk(pwr_en == 8'h01 && iso == 8'hFE, "R7 R9 retired state", {pwr_en, iso}, 16'h01FE);
      if (t.wb) chk(ret[7], "R7 writeback retention after retire", ret, 8'h80);
    end

    run_one(32'h003100B3, 1'b0, 1'b1, 1'b1, 32'h023100B3);
    chk(!seen[4], "R9 busy fetch_valid ignored (no muldiv power)", seen, 8'h87);
    chk(busy == exp_len(1'b0, 1'b1, 1'b1), "R9 busy length unchanged", busy, exp_len(1'b0, 1'b1, 1'b1));
    chk(nact == 4, "R9 no extra strobes", nact, 4);
    repeat (5) begin
      @(negedge clk);
      chk(idle && pwr_en == 8'h01 && stage_act == 8'h00, "R9 stays idle without fetch_valid",
          {idle, pwr_en}, 9'h101);
    end

    fixed_mode = 1'b1; fast = 1'b1;
    run_one(32'h00208063, 1'b1, 1'b1, 1'b0, 32'h0);
    chk(busy == 2 * SLOT + 2, "R6 fixed slot with fast ack", busy, 2 * SLOT + 2);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(ret == 8'h00 && pwr_en == 8'h01 && iso == 8'hFE, "R1 second reset clears retention",
        {ret, pwr_en, iso}, 24'h0001FE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule